// File: doc/BRIEF.md
# Multichannel DAC register bank

This block holds the digital state of an eight-channel voltage-output converter. It accepts 16-bit command words that have already been received and committed. The top four bits of a word pick a target and the low twelve bits carry the payload. A word can write one channel, write a pair of channels (one of them receives the complement), update one of two control registers, or set a preset code. Each channel is double-buffered. A write lands in a holding register, and the converter sees a separate output latch.

Two active-low pins act on the output stage. While the load pin is low, every output latch copies its holding register on each cycle, so a pin tied low makes the outputs follow the writes. While the preset pin is low, all eight output codes show the stored preset code and latch updates are suspended. Both pins may change at any time. Each passes through a two-stage synchronizer, so its effect appears two clock edges after the change. A resolution parameter (12, 10 or 8) clears the data bits that a narrower converter does not use.

Words arrive on a valid/ready stream. `cmd_ready` is low while reset is applied and high on every cycle after that, so a word is taken on any rising edge where `cmd_valid` is high. Back-pressure never occurs. A source may present a new word on every cycle, and there is no word boundary to respect.

Top module: `dac_regbank`

## Requirements
- R1: A word with address 0..7 (bits 15:12) writes its data into the holding register of channel 0..7. The output code of that channel does not change while the load pin is high.
- R2: While `load_n` is low and `preset_n` is high, each output latch takes its holding value on every cycle. Holding `load_n` low makes each write appear on `ch_code` one cycle after it lands.
- R3: Addresses 12..15 write pairs (0,1), (2,3), (4,5) and (6,7). The lower channel gets the data and the higher channel gets its bitwise complement, limited to the kept resolution bits.
- R4: Address 10 stores the preset code. While `preset_n` is low, all eight outputs equal that code. Preset takes priority over load: latches do not update while preset is active, even if `load_n` is low.
- R5: Address 8 writes control word 0. Data bit 4 drives `global_pd`, bit 3 drives `cascade_en` and bit 0 selects the input format (1 = twos complement). Its other data bits are ignored, and the flags change only on a control write.
- R6: Address 9 writes control word 1. Data bits 7:4 drive `pair_pd[3:0]` and bits 3:0 drive `pair_fast[3:0]`, with index 0 the pair (0,1) and index 3 the pair (6,7). Bits 11:8 are ignored.
- R7: A word with address 11 changes no register and no output.
- R8: After reset, every holding register, latch, the preset code and both control words read zero.
- R9: With `RES_BITS` = 10, data bits 1:0 are stored as zero. With `RES_BITS` = 8, bits 3:0 are stored as zero. This applies to channel, pair and preset writes.
- R10: When the twos-complement format is selected, channel and pair data have bit 11 inverted before they are stored. Preset data is stored unchanged.
- R11: `cmd_ready` is low during reset and high on every cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted when high with valid |
| cmd_data | input | 16 | Command word: address in 15:12, data in 11:0 |
| load_n | input | 1 | Active-low latch load, asynchronous |
| preset_n | input | 1 | Active-low preset override, asynchronous |
| ch_code | output | 96 | Eight 12-bit output codes, channel i in bits 12i+11:12i |
| pair_pd | output | 4 | Per-pair power-down flags |
| pair_fast | output | 4 | Per-pair speed flags, 1 = fast |
| global_pd | output | 1 | Whole-converter power-down flag |
| cascade_en | output | 1 | Cascade output enable flag |

## Verification
The bench builds two copies of the block, one at the default `RES_BITS` of 12 and one at 8, and drives both with the same word stream and pin activity. The 12-bit copy makes the full-width behaviour visible: pair complements, the inverted bit 11 in twos-complement format, and preset codes across all bits. The 8-bit copy shows that the low nibble is cleared for channel, pair and preset writes and that the complement stays inside the kept bits. Releasing preset and load in the same cycle after a write made under preset shows that preset takes priority over load.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  localparam int NUM_CH   = 8;
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int CODE_W   = 12;
  localparam int ADDR_W   = 4;
  localparam int WORD_W   = ADDR_W + CODE_W;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CHAN,
    OP_PAIR,
    OP_CTRL0,
    OP_CTRL1,
    OP_PRESET
  } op_e;

  typedef struct packed {
    logic pwr_down;
    logic casc_en;
    logic twos;
  } ctrl0_t;

  typedef struct packed {
    logic [NUM_PAIR-1:0] pd;
    logic [NUM_PAIR-1:0] fast;
  } ctrl1_t;

  // bits kept for a given resolution, lowest (CODE_W - rb) bits cleared
  function automatic logic [CODE_W-1:0] keep_mask(int unsigned rb);
    logic [31:0] low;
    low = (32'h1 << (CODE_W - rb)) - 32'h1;
    return ~low[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] act
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= ~pin_n;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign act = chain_q[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_regbank_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                          fire,
  input  logic [WORD_W-1:0]             word,
  input  logic                          twos,
  output op_e                           op,
  output logic [NUM_CH-1:0]             hold_we,
  output logic [NUM_CH-1:0][CODE_W-1:0] hold_wd,
  output logic [CODE_W-1:0]             preset_wd,
  output ctrl0_t                        ctrl0_wd,
  output ctrl1_t                        ctrl1_wd
);
  localparam logic [CODE_W-1:0] KEEP = keep_mask(RES_BITS);
  localparam logic [CODE_W-1:0] MSB_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] raw;
  logic [CODE_W-1:0] conv;
  logic [CODE_W-1:0] comp;

  assign addr = word[WORD_W-1:CODE_W];
  assign raw  = word[CODE_W-1:0];

  // offset-binary conversion, then resolution clipping
  assign conv = (twos ? (raw ^ MSB_FLIP) : raw) & KEEP;
  assign comp = ~conv & KEEP;

  always_comb begin
    op = OP_NONE;
    if (fire) begin
      if (!addr[ADDR_W-1]) begin
        op = OP_CHAN;
      end else begin
        case (addr[2:0])
          3'd0:    op = OP_CTRL0;
          3'd1:    op = OP_CTRL1;
          3'd2:    op = OP_PRESET;
          3'd3:    op = OP_NONE;
          default: op = OP_PAIR;
        endcase
      end
    end
  end

  always_comb begin
    hold_we = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      hold_wd[i] = conv;
    end
    if (op == OP_CHAN) begin
      hold_we[addr[2:0]] = 1'b1;
    end else if (op == OP_PAIR) begin
      hold_we[{addr[1:0], 1'b0}] = 1'b1;
      hold_we[{addr[1:0], 1'b1}] = 1'b1;
      hold_wd[{addr[1:0], 1'b1}] = comp;
    end
  end

  assign preset_wd      = raw & KEEP;
  assign ctrl0_wd.pwr_down = raw[4];
  assign ctrl0_wd.casc_en  = raw[3];
  assign ctrl0_wd.twos     = raw[0];
  assign ctrl1_wd.pd    = raw[7:4];
  assign ctrl1_wd.fast  = raw[3:0];
endmodule

// File: rtl/dac_chan_stage.sv
module dac_chan_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_code,
  input  logic         load_en,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (wr_en) begin
      hold_q <= wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (load_en) begin
      latch_q <= hold_q;
    end
  end
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [15:0]              cmd_data,
  input  logic                     load_n,
  input  logic                     preset_n,
  output logic [NUM_CH*CODE_W-1:0] ch_code,
  output logic [NUM_PAIR-1:0]      pair_pd,
  output logic [NUM_PAIR-1:0]      pair_fast,
  output logic                     global_pd,
  output logic                     cascade_en
);
  logic                          fire;
  op_e                           op;
  logic [NUM_CH-1:0]             hold_we;
  logic [NUM_CH-1:0][CODE_W-1:0] hold_wd;
  logic [NUM_CH-1:0][CODE_W-1:0] latch_q;
  logic [CODE_W-1:0]             preset_wd;
  logic [CODE_W-1:0]             preset_q;
  ctrl0_t                        ctrl0_wd;
  ctrl0_t                        ctrl0_q;
  ctrl1_t                        ctrl1_wd;
  ctrl1_t                        ctrl1_q;
  logic [1:0]                    pin_act;
  logic                          load_act;
  logic                          preset_act;
  logic                          load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  assign fire = cmd_valid && cmd_ready;

  dac_cmd_decode #(.RES_BITS(RES_BITS)) u_decode (
    .fire      (fire),
    .word      (cmd_data),
    .twos      (ctrl0_q.twos),
    .op        (op),
    .hold_we   (hold_we),
    .hold_wd   (hold_wd),
    .preset_wd (preset_wd),
    .ctrl0_wd  (ctrl0_wd),
    .ctrl1_wd  (ctrl1_wd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q  <= '0;
      ctrl1_q  <= '0;
      preset_q <= '0;
    end else begin
      if (op == OP_CTRL0)  ctrl0_q  <= ctrl0_wd;
      if (op == OP_CTRL1)  ctrl1_q  <= ctrl1_wd;
      if (op == OP_PRESET) preset_q <= preset_wd;
    end
  end

  dac_pin_sync #(.WIDTH(2), .STAGES(2)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n ({preset_n, load_n}),
    .act   (pin_act)
  );

  assign load_act   = pin_act[0];
  assign preset_act = pin_act[1];
  // preset wins: latches freeze while the override is shown
  assign load_en    = load_act && !preset_act;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dac_chan_stage #(.W(CODE_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hold_we[g]),
      .wr_code (hold_wd[g]),
      .load_en (load_en),
      .latch_q (latch_q[g])
    );
    assign ch_code[g*CODE_W +: CODE_W] = preset_act ? preset_q : latch_q[g];
  end

  assign pair_pd    = ctrl1_q.pd;
  assign pair_fast  = ctrl1_q.fast;
  assign global_pd  = ctrl0_q.pwr_down;
  assign cascade_en = ctrl0_q.casc_en;
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
  import dac_regbank_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic                     cmd_ready,
  input logic [ADDR_W-1:0]        cmd_addr,
  input logic [7:0]               cmd_lo,
  input logic                     preset_act,
  input logic [NUM_CH*CODE_W-1:0] ch_code,
  input logic [NUM_PAIR-1:0]      pair_pd,
  input logic [NUM_PAIR-1:0]      pair_fast,
  input logic                     global_pd,
  input logic                     cascade_en
);
  localparam int LOW_CLR = CODE_W - RES_BITS;

  logic wr;
  logic ctrl_wr;
  assign wr      = cmd_valid && cmd_ready;
  assign ctrl_wr = wr && (cmd_addr == 4'd8 || cmd_addr == 4'd9);

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmd_ready); // R11

  AST_CTRL0_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_addr == 4'd8) |=> (global_pd == $past(cmd_lo[4]) && cascade_en == $past(cmd_lo[3]))); // R5

  AST_FLAGS_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable({pair_pd, pair_fast, global_pd, cascade_en})); // R5

  AST_CTRL1_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_addr == 4'd9) |=> ({pair_pd, pair_fast} == $past(cmd_lo))); // R6

  AST_RESERVED_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_addr == 4'd11) |=> $stable({pair_pd, pair_fast, global_pd, cascade_en})); // R7

  AST_PRESET_ALL_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    preset_act |-> (ch_code == {NUM_CH{ch_code[CODE_W-1:0]}})); // R4

  if (LOW_CLR > 0) begin : g_res
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ch_code[c*CODE_W +: LOW_CLR] == '0); // R9
    end
  end
endmodule

bind dac_regbank dac_regbank_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_addr   (cmd_data[15:12]),
  .cmd_lo     (cmd_data[7:0]),
  .preset_act (preset_act),
  .ch_code    (ch_code),
  .pair_pd    (pair_pd),
  .pair_fast  (pair_fast),
  .global_pd  (global_pd),
  .cascade_en (cascade_en)
);

// File: tb/dac_regbank_bench.sv
module dac_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_data;
  logic        load_n;
  logic        preset_n;

  logic [95:0] code_a, code_b;
  logic        rdy_a, rdy_b;
  logic [3:0]  ppd_a, ppd_b, pf_a, pf_b;
  logic        gpd_a, gpd_b, cas_a, cas_b;

  always #5 clk = ~clk;

  dac_regbank #(.RES_BITS(12)) u_dac_regbank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_a),
    .cmd_data(cmd_data), .load_n(load_n), .preset_n(preset_n),
    .ch_code(code_a), .pair_pd(ppd_a), .pair_fast(pf_a),
    .global_pd(gpd_a), .cascade_en(cas_a));

  dac_regbank #(.RES_BITS(8)) u_dac_regbank_r8 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy_b),
    .cmd_data(cmd_data), .load_n(load_n), .preset_n(preset_n),
    .ch_code(code_b), .pair_pd(ppd_b), .pair_fast(pf_b),
    .global_pd(gpd_b), .cascade_en(cas_b));

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model, index 0 = 12-bit copy, 1 = 8-bit copy
  logic [11:0] m_hold [2][8];
  logic [11:0] m_lat  [2][8];
  logic [11:0] m_pre  [2];
  logic        m_twos, m_gpd, m_casc;
  logic [3:0]  m_ppd, m_pf;
  bit          m_ld, m_pr;

  function automatic logic [11:0] bmask(int r);
    return (r == 0) ? 12'hFFF : 12'hFF0;
  endfunction

  task automatic model_write(input logic [15:0] w);
    logic [11:0] d, v;
    int a;
    a = int'(w[15:12]);
    d = w[11:0];
    for (int r = 0; r < 2; r++) begin
      v = (m_twos ? {~d[11], d[10:0]} : d) & bmask(r);
      if (a < 8) m_hold[r][a] = v;
      else if (a >= 12) begin
        m_hold[r][2*(a-12)]   = v;
        m_hold[r][2*(a-12)+1] = ~v & bmask(r);
      end else if (a == 10) m_pre[r] = d & bmask(r);
    end
    if (a == 8) begin
      m_gpd = d[4]; m_casc = d[3]; m_twos = d[0];
    end else if (a == 9) begin
      m_ppd = d[7:4]; m_pf = d[3:0];
    end
    if (m_ld && !m_pr)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 8; c++) m_lat[r][c] = m_hold[r][c];
  endtask

  task automatic check(input string req);
    logic [11:0] got, exp;
    for (int r = 0; r < 2; r++) begin
      n_vec++;
      for (int c = 0; c < 8; c++) begin
        got = (r == 0) ? code_a[c*12 +: 12] : code_b[c*12 +: 12];
        exp = m_pr ? m_pre[r] : m_lat[r][c];
        if (got !== exp) begin
          n_bad++;
          $display("FAIL %s copy%0d ch%0d code actual %h expected %h", req, r, c, got, exp);
        end
      end
      if (((r == 0) ? {ppd_a, pf_a, gpd_a, cas_a} : {ppd_b, pf_b, gpd_b, cas_b})
          !== {m_ppd, m_pf, m_gpd, m_casc}) begin
        n_bad++;
        $display("FAIL %s copy%0d flags actual %b expected %b", req, r,
                 (r == 0) ? {ppd_a, pf_a, gpd_a, cas_a} : {ppd_b, pf_b, gpd_b, cas_b},
                 {m_ppd, m_pf, m_gpd, m_casc});
      end
    end
  endtask

  task automatic check_ready(input string req, input logic exp);
    n_vec++;
    if (rdy_a !== exp || rdy_b !== exp) begin
      n_bad++;
      $display("FAIL %s ready actual %b/%b expected %b", req, rdy_a, rdy_b, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_write(w);
    @(negedge clk);
  endtask

  task automatic set_pins(input bit ld, input bit pr);
    @(negedge clk);
    load_n   = ~ld;
    preset_n = ~pr;
    repeat (4) @(negedge clk);
    m_ld = ld;
    m_pr = pr;
    if (ld && !pr)
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 8; c++) m_lat[r][c] = m_hold[r][c];
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; load_n = 1'b1; preset_n = 1'b1;
    for (int r = 0; r < 2; r++) begin
      m_pre[r] = '0;
      for (int c = 0; c < 8; c++) begin m_hold[r][c] = '0; m_lat[r][c] = '0; end
    end
    m_twos = 0; m_gpd = 0; m_casc = 0; m_ppd = '0; m_pf = '0; m_ld = 0; m_pr = 0;
    repeat (3) @(negedge clk);
    check_ready("R11 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_ready("R11 after reset", 1'b1);
    check("R8 reset state");
  endtask

  task automatic t_hold_only;
    for (int c = 0; c < 8; c++) send({4'(c), 12'(12'h135 * (c + 1))});
    check("R1 holding written, outputs unchanged");
  endtask

  task automatic t_load;
    set_pins(1, 0);
    check("R2 load copies holding");
    set_pins(0, 0);
    send(16'h3ABC);
    check("R2 no update with load high");
    set_pins(1, 0);
    send(16'h6123);
    check("R2 transparent with load low");
  endtask

  task automatic t_pair;
    send(16'hD5A3);
    check("R3 pair 2/3 complement");
    send(16'hC000);
    check("R3 pair 0/1 zero");
    send(16'hFFFF);
    check("R3 pair 6/7 full scale");
  endtask

  task automatic t_res;
    send(16'h1FFF);
    send(16'h2ABF);
    check("R9 resolution clears low bits");
  endtask

  task automatic t_twos;
    send(16'h8001);
    check("R10 format select");
    send(16'h0000);
    send(16'h77FF);
    check("R10 bit 11 inverted");
    send(16'hE123);
    check("R10 pair in twos format");
    send(16'h8000);
    send(16'h5800);
    check("R10 straight binary restored");
  endtask

  task automatic t_ctrl;
    send(16'h8019);
    check("R5 control 0 flags set");
    send(16'h8FE6);
    check("R5 control 0 ignored bits");
    send(16'h90A5);
    check("R6 control 1 fields");
    send(16'h9F5A);
    check("R6 control 1 high bits ignored");
  endtask

  task automatic t_reserved;
    send(16'hBFFF);
    check("R7 reserved address no effect");
    send(16'hB000);
    check("R7 reserved address zero data");
  endtask

  task automatic t_preset;
    send(16'hA3C7);
    check("R4 preset stored, pin high");
    set_pins(1, 1);
    check("R4 preset drives all outputs");
    send(16'h0555);
    check("R4 write under preset hidden");
    set_pins(0, 0);
    check("R4 preset priority over load");
    set_pins(1, 0);
    check("R4 latch follows after release");
  endtask

  initial begin
    t_reset();
    t_hold_only();
    t_load();
    t_pair();
    t_res();
    t_twos();
    t_ctrl();
    t_reserved();
    t_preset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule